// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Per-Side Real-Mode Attributes

This block translates effective addresses into physical addresses for a 32-bit core that has separate instruction-fetch and data-access paths. It holds a small, fully associative table of page mappings. Software fills the table one word at a time: it picks an entry index and says whether it is writing the tag word or the data word. Each entry may cover a page from 1 KB to 16 MB. Each side of the core presents its own lookup. The block answers at once with a physical address, cache-inhibit and write-through attributes, and flags for a miss, a permission fault and a usable access.

Each side has its own translate enable. The core clears these enables when it takes an interrupt or a system call. While a side's enable is low, that side is in real mode. The address passes through untranslated, and the cache attributes come from per-side cacheability registers and a shared write-through register. Each of these registers gives one bit to each 128 MB region of the address space. Software must keep the real-mode attributes consistent with the page attributes of memory that both modes touch. The block itself only reports the attributes that each mode selects.

Raising the miss and fault flags is the whole of the block's error handling. What the core does with them is outside this block.

Top module: `tlbx_top`

## Requirements
- R1: After reset every entry is invalid, so a translated lookup with a request raises miss. Both cacheability registers and the write-through register are zero, so every real-mode access reports inhibit=1 and wthru=0.
- R2: Tag word field positions, given as bit indices with bit 31 as the MSB:
  - bits [31:10] hold the effective page number.
  - bits [9:7] hold a size code s, where 0 to 7 select 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB; the page holds 2^(10+2s) bytes.
  - bit [6] is the valid bit.
  - Example: 0x00000340 is a valid 4 MB page at address 0.
  - A lookup matches an entry when the entry is valid and the address bits above the page offset are equal.
- R3: Data word field positions:
  - bits [31:10] hold the real page number.
  - bit 9 (0x200) is execute enable and bit 8 (0x100) is write enable.
  - bit 3 (0x8) is write-through and bit 2 (0x4) is cache inhibit.
  - On a hit, pa takes the real page bits above the page offset and the offset bits from the effective address; inhibit and wthru take the entry's bits.
- R4: When several valid entries match an address, the entry with the lowest index supplies the result.
- R5: With translation on and a request, and no valid entry matching, the side raises miss and drops ok; pa, inhibit and wthru are then 0.
- R6: A fetch that hits an entry with execute enable clear, or a data store that hits an entry with write enable clear, raises fault and drops ok. A data load needs neither bit.
- R7: With translation off, pa equals the effective address and miss and fault stay low; ok follows the request.
- R8: The cfg port selects a register with cfg_sel: 0 is the instruction cacheability register, 1 the data cacheability register, 2 the write-through register, and 3 writes nothing. In real mode, inhibit is the inverse of register bit 31-k, where k = ea[31:27] is the 128 MB region (bit 31 covers 0x00000000 to 0x07FFFFFF).
- R9: In real mode, wthru is bit 31-k of the write-through register, with k = ea[31:27], on both sides.
- R10: A table write takes effect at the clock edge that samples it. A lookup in the same cycle as the write still sees the old entry, and a lookup in the next cycle sees the new one.
- R11: The two translate enables act independently: one side can translate while the other is in real mode, against the same table.
- R12: miss, fault and ok are low on a side whose request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 6 | Entry index for the write |
| tbl_word | input | 1 | 0 writes the tag word, 1 writes the data word |
| tbl_wdata | input | 32 | Word written into the entry |
| cfg_we | input | 1 | Real-mode register write strobe |
| cfg_sel | input | 2 | Register select (see R8) |
| cfg_wdata | input | 32 | Real-mode register value |
| i_xlate | input | 1 | Instruction-side translate enable |
| i_req | input | 1 | Instruction fetch request |
| i_ea | input | 32 | Fetch effective address |
| i_pa | output | 32 | Fetch physical address |
| i_inhibit | output | 1 | Fetch cache-inhibit attribute |
| i_wthru | output | 1 | Fetch write-through attribute |
| i_miss | output | 1 | Fetch translation miss |
| i_fault | output | 1 | Fetch execute-permission fault |
| i_ok | output | 1 | Fetch may proceed |
| d_xlate | input | 1 | Data-side translate enable |
| d_req | input | 1 | Data access request |
| d_store | input | 1 | 1 for a store, 0 for a load |
| d_ea | input | 32 | Data effective address |
| d_pa | output | 32 | Data physical address |
| d_inhibit | output | 1 | Data cache-inhibit attribute |
| d_wthru | output | 1 | Data write-through attribute |
| d_miss | output | 1 | Data translation miss |
| d_fault | output | 1 | Data write-permission fault |
| d_ok | output | 1 | Data access may proceed |

## Verification
Every lookup result is combinational from the side's inputs and the registered table, so it is due in the same cycle as its request. The bench drives inputs on the falling edge and compares one nanosecond later, before the next rising edge. Table and register writes become visible only after one rising edge. The bench therefore updates its reference model after that edge, and one directed case looks up a changed entry both in the write cycle, where it expects the old result, and in the cycle after, where it expects the new one.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int AW = 32;
    localparam int PN_W = 22;
    localparam int SZ_W = 3;
    localparam int REGION_W = 5;

    typedef struct packed {
        logic [PN_W-1:0] epn;
        logic [SZ_W-1:0] size;
        logic            valid;
    } tag_f_t;

    typedef struct packed {
        logic [PN_W-1:0] rpn;
        logic            ex_en;
        logic            wr_en;
        logic            wthru;
        logic            inhibit;
    } data_f_t;

    typedef struct packed {
        logic [AW-1:0] pa;
        logic          inhibit;
        logic          wthru;
        logic          miss;
        logic          fault;
        logic          ok;
    } look_res_t;

    function automatic logic [AW-1:0] page_off_mask(input logic [SZ_W-1:0] sz);
        logic [5:0] sh;
        sh = 6'd10 + {2'b00, sz, 1'b0};
        return (AW'(1) << sh) - AW'(1);
    endfunction

endpackage

// File: rtl/tlbx_entry_store.sv
module tlbx_entry_store
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IW = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IW-1:0]        idx,
    input  logic                 word_sel,
    input  logic [AW-1:0]        wdata,
    output tag_f_t  [N_ENT-1:0]  tags_q,
    output data_f_t [N_ENT-1:0]  datas_q
);

    tag_f_t  tag_next;
    data_f_t data_next;
    logic    unused_wbits;

    assign tag_next  = tag_f_t'({wdata[31:10], wdata[9:7], wdata[6]});
    assign data_next = data_f_t'({wdata[31:10], wdata[9], wdata[8], wdata[3], wdata[2]});
    assign unused_wbits = ^{wdata[5:4], wdata[1:0]};

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic hit_w;
        assign hit_w = we && (idx == IW'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tags_q[e]  <= '0;
                datas_q[e] <= '0;
            end else if (hit_w) begin
                if (word_sel) datas_q[e] <= data_next;
                else          tags_q[e]  <= tag_next;
            end
        end
    end

endmodule

// File: rtl/tlbx_realmode_regs.sv
module tlbx_realmode_regs
    import tlbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] i_cache_q,
    output logic [AW-1:0] d_cache_q,
    output logic [AW-1:0] wthru_q
);

    typedef enum logic [1:0] {
        SEL_ICACHE = 2'd0,
        SEL_DCACHE = 2'd1,
        SEL_WTHRU  = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    cfg_sel_e sel_e;
    assign sel_e = cfg_sel_e'(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_cache_q <= '0;
            d_cache_q <= '0;
            wthru_q   <= '0;
        end else if (we) begin
            unique case (sel_e)
                SEL_ICACHE: i_cache_q <= wdata;
                SEL_DCACHE: d_cache_q <= wdata;
                SEL_WTHRU:  wthru_q   <= wdata;
                SEL_NONE:   ;
            endcase
        end
    end

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter bit FETCH_SIDE = 1'b0,
    localparam int IW = $clog2(N_ENT)
) (
    input  tag_f_t  [N_ENT-1:0] tags,
    input  data_f_t [N_ENT-1:0] datas,
    input  logic                xlate,
    input  logic                req,
    input  logic                store,
    input  logic [AW-1:0]       ea,
    input  logic [AW-1:0]       rm_cache,
    input  logic [AW-1:0]       rm_wthru,
    output look_res_t           res
);

    logic [N_ENT-1:0] match;
    logic             any_hit;
    logic [IW-1:0]    hit_idx;
    data_f_t          sel_data;
    logic [AW-1:0]    sel_mask;
    logic [REGION_W-1:0] region;
    logic             perm_bad;

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        logic [AW-1:0] keep;
        assign keep = ~page_off_mask(tags[e].size);
        assign match[e] = tags[e].valid &&
                          ((({tags[e].epn, 10'b0} ^ ea) & keep) == '0);
    end

    // lowest index wins: descending scan, last assignment stands
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            if (match[k]) begin
                any_hit = 1'b1;
                hit_idx = IW'(k);
            end
        end
    end

    assign sel_data = datas[hit_idx];
    assign sel_mask = page_off_mask(tags[hit_idx].size);
    assign region   = ea[AW-1 -: REGION_W];

    generate
        if (FETCH_SIDE) begin : g_fetch_perm
            assign perm_bad = !sel_data.ex_en;
        end else begin : g_data_perm
            assign perm_bad = store && !sel_data.wr_en;
        end
    endgenerate

    always_comb begin
        res = '0;
        if (!xlate) begin
            res.pa      = ea;
            res.inhibit = !rm_cache[~region];
            res.wthru   = rm_wthru[~region];
            res.ok      = req;
        end else if (any_hit) begin
            res.pa      = ({sel_data.rpn, 10'b0} & ~sel_mask) | (ea & sel_mask);
            res.inhibit = sel_data.inhibit;
            res.wthru   = sel_data.wthru;
            res.fault   = req && perm_bad;
            res.ok      = req && !perm_bad;
        end else begin
            res.miss    = req;
        end
    end

endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IW = $clog2(N_ENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic [IW-1:0] tbl_idx,
    input  logic          tbl_word,
    input  logic [31:0]   tbl_wdata,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          i_xlate,
    input  logic          i_req,
    input  logic [31:0]   i_ea,
    output logic [31:0]   i_pa,
    output logic          i_inhibit,
    output logic          i_wthru,
    output logic          i_miss,
    output logic          i_fault,
    output logic          i_ok,
    input  logic          d_xlate,
    input  logic          d_req,
    input  logic          d_store,
    input  logic [31:0]   d_ea,
    output logic [31:0]   d_pa,
    output logic          d_inhibit,
    output logic          d_wthru,
    output logic          d_miss,
    output logic          d_fault,
    output logic          d_ok
);

    tag_f_t  [N_ENT-1:0] tags_q;
    data_f_t [N_ENT-1:0] datas_q;
    logic [AW-1:0] i_cache_q, d_cache_q, wthru_q;
    look_res_t i_res, d_res;

    tlbx_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .idx(tbl_idx),
        .word_sel(tbl_word), .wdata(tbl_wdata),
        .tags_q(tags_q), .datas_q(datas_q)
    );

    tlbx_realmode_regs u_rm (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .i_cache_q(i_cache_q), .d_cache_q(d_cache_q), .wthru_q(wthru_q)
    );

    tlbx_lookup #(.N_ENT(N_ENT), .FETCH_SIDE(1'b1)) u_ilook (
        .tags(tags_q), .datas(datas_q), .xlate(i_xlate), .req(i_req),
        .store(1'b0), .ea(i_ea), .rm_cache(i_cache_q), .rm_wthru(wthru_q),
        .res(i_res)
    );

    tlbx_lookup #(.N_ENT(N_ENT), .FETCH_SIDE(1'b0)) u_dlook (
        .tags(tags_q), .datas(datas_q), .xlate(d_xlate), .req(d_req),
        .store(d_store), .ea(d_ea), .rm_cache(d_cache_q), .rm_wthru(wthru_q),
        .res(d_res)
    );

    assign i_pa      = i_res.pa;
    assign i_inhibit = i_res.inhibit;
    assign i_wthru   = i_res.wthru;
    assign i_miss    = i_res.miss;
    assign i_fault   = i_res.fault;
    assign i_ok      = i_res.ok;

    assign d_pa      = d_res.pa;
    assign d_inhibit = d_res.inhibit;
    assign d_wthru   = d_res.wthru;
    assign d_miss    = d_res.miss;
    assign d_fault   = d_res.fault;
    assign d_ok      = d_res.ok;

endmodule

// File: rtl/tlbx_checker.sv
module tlbx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        i_xlate,
    input logic        i_req,
    input logic [31:0] i_ea,
    input logic [31:0] i_pa,
    input logic        i_miss,
    input logic        i_fault,
    input logic        i_ok,
    input logic        d_xlate,
    input logic        d_req,
    input logic        d_store,
    input logic [31:0] d_ea,
    input logic [31:0] d_pa,
    input logic        d_miss,
    input logic        d_fault,
    input logic        d_ok
);

    assert_i_real_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !i_xlate |-> (i_pa == i_ea) && !i_miss && !i_fault);

    assert_d_real_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !d_xlate |-> (d_pa == d_ea) && !d_miss && !d_fault);

    assert_miss_blocks_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_miss |-> !i_ok && !i_fault) and (d_miss |-> !d_ok && !d_fault));

    assert_fault_blocks_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_fault |-> !i_ok) and (d_fault |-> !d_ok && d_store));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_req |-> !i_miss && !i_fault && !i_ok) and
        (!d_req |-> !d_miss && !d_fault && !d_ok));

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_miss, i_fault, i_ok}) && $onehot0({d_miss, d_fault, d_ok}));

endmodule

bind tlbx_top tlbx_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .i_xlate(i_xlate), .i_req(i_req), .i_ea(i_ea), .i_pa(i_pa),
    .i_miss(i_miss), .i_fault(i_fault), .i_ok(i_ok),
    .d_xlate(d_xlate), .d_req(d_req), .d_store(d_store), .d_ea(d_ea), .d_pa(d_pa),
    .d_miss(d_miss), .d_fault(d_fault), .d_ok(d_ok)
);

// File: tb/tlbx_top_tb.sv
module tlbx_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        tbl_we = 0, tbl_word = 0, cfg_we = 0;
    logic [5:0]  tbl_idx = 0;
    logic [31:0] tbl_wdata = 0, cfg_wdata = 0;
    logic [1:0]  cfg_sel = 0;
    logic        i_xlate = 0, i_req = 0, d_xlate = 0, d_req = 0, d_store = 0;
    logic [31:0] i_ea = 0, d_ea = 0;
    logic [31:0] i_pa, d_pa;
    logic        i_inhibit, i_wthru, i_miss, i_fault, i_ok;
    logic        d_inhibit, d_wthru, d_miss, d_fault, d_ok;

    tlbx_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_word(tbl_word), .tbl_wdata(tbl_wdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .i_xlate(i_xlate), .i_req(i_req), .i_ea(i_ea), .i_pa(i_pa),
        .i_inhibit(i_inhibit), .i_wthru(i_wthru), .i_miss(i_miss), .i_fault(i_fault), .i_ok(i_ok),
        .d_xlate(d_xlate), .d_req(d_req), .d_store(d_store), .d_ea(d_ea), .d_pa(d_pa),
        .d_inhibit(d_inhibit), .d_wthru(d_wthru), .d_miss(d_miss), .d_fault(d_fault), .d_ok(d_ok)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_tag [64];
    logic [31:0] m_dat [64];
    logic [31:0] m_ic, m_dc, m_wt;

    // result vector: {pa[36:5], inhibit, wthru, miss, fault, ok}
    function automatic logic [36:0] model(input bit xl, input bit req, input bit fetch,
                                          input bit st, input logic [31:0] ea,
                                          input logic [31:0] ccr);
        logic [31:0] pa, msk;
        logic inh, wt, ms, ft, ok;
        int r, hit;
        pa = 0; inh = 0; wt = 0; ms = 0; ft = 0; ok = 0;
        r = 31 - int'(ea[31:27]);
        if (!xl) begin
            pa = ea; inh = !ccr[r]; wt = m_wt[r]; ok = req;
        end else begin
            hit = -1;
            for (int k = 0; k < 64; k++) begin
                if (hit < 0 && m_tag[k][6]) begin
                    msk = (32'd1 << (10 + 2 * int'(m_tag[k][9:7]))) - 1;
                    if (((m_tag[k] ^ ea) & ~msk & 32'hFFFF_FC00) == 0) hit = k;
                end
            end
            if (hit < 0) ms = req;
            else begin
                msk = (32'd1 << (10 + 2 * int'(m_tag[hit][9:7]))) - 1;
                pa  = (m_dat[hit] & 32'hFFFF_FC00 & ~msk) | (ea & msk);
                inh = m_dat[hit][2];
                wt  = m_dat[hit][3];
                if (fetch ? !m_dat[hit][9] : (st && !m_dat[hit][8])) ft = req;
                else ok = req;
            end
        end
        return {pa, inh, wt, ms, ft, ok};
    endfunction

    task automatic cmp(input string req_tag, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic check_both(input string req_tag);
        cmp({req_tag, " i-side"}, {i_pa, i_inhibit, i_wthru, i_miss, i_fault, i_ok},
            model(i_xlate, i_req, 1'b1, 1'b0, i_ea, m_ic));
        cmp({req_tag, " d-side"}, {d_pa, d_inhibit, d_wthru, d_miss, d_fault, d_ok},
            model(d_xlate, d_req, 1'b0, d_store, d_ea, m_dc));
    endtask

    task automatic lookup(input bit ix, input bit ir, input logic [31:0] ia,
                          input bit dx, input bit dr, input bit ds, input logic [31:0] da,
                          input string req_tag);
        @(negedge clk);
        i_xlate = ix; i_req = ir; i_ea = ia;
        d_xlate = dx; d_req = dr; d_store = ds; d_ea = da;
        #1;
        check_both(req_tag);
    endtask

    task automatic tbl_write(input int idx, input bit word, input logic [31:0] v);
        @(negedge clk);
        tbl_we = 1; tbl_idx = 6'(idx); tbl_word = word; tbl_wdata = v;
        @(posedge clk);
        #0.5;
        if (word) m_dat[idx] = v; else m_tag[idx] = v;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
        @(posedge clk);
        #0.5;
        case (sel)
            2'd0: m_ic = v;
            2'd1: m_dc = v;
            2'd2: m_wt = v;
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] base, a1, a2;
        void'($urandom(32'd4242));
        for (int k = 0; k < 64; k++) begin m_tag[k] = 0; m_dat[k] = 0; end
        m_ic = 0; m_dc = 0; m_wt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        lookup(0, 1, 32'h0000_1000, 0, 1, 0, 32'hF800_0004, "R1 real-mode inhibited");
        lookup(1, 1, 32'h0000_0100, 1, 1, 1, 32'h1234_5678, "R1 empty table miss");
        // R12: idle side quiet
        lookup(1, 0, 32'h0000_0100, 0, 0, 0, 32'h1234_5678, "R12 no request");

        // R8, R9: real-mode registers
        cfg_write(2'd0, 32'h8000_0000);
        cfg_write(2'd1, 32'hA000_0001);
        cfg_write(2'd2, 32'h4000_0001);
        cfg_write(2'd3, 32'hFFFF_FFFF); // R8: select 3 writes nothing
        lookup(0, 1, 32'h0000_5000, 0, 1, 0, 32'h0800_0000, "R8 region bits");
        lookup(0, 1, 32'h1000_0000, 0, 1, 1, 32'hF800_0000, "R9 write-through region");
        lookup(0, 1, 32'h0800_0000, 0, 1, 0, 32'h4000_0000, "R8 sel3 ignored");

        // R2, R3, R6: directed pages
        tbl_write(0, 0, 32'h0000_0340);
        tbl_write(0, 1, 32'h0000_0300);
        tbl_write(1, 0, 32'h0040_0340);
        tbl_write(1, 1, 32'h0040_0104);
        lookup(1, 1, 32'h0000_5000, 1, 1, 1, 32'h0040_0010, "R2 4MB page hit");
        lookup(1, 1, 32'h0040_0010, 1, 1, 0, 32'h0040_0020, "R6 fetch without execute");
        // R6: store to read-only page
        tbl_write(2, 0, 32'h2000_03C0);
        tbl_write(2, 1, 32'h7000_0208);
        lookup(1, 1, 32'h20AB_CDEF, 1, 1, 1, 32'h2012_3456, "R6 store without write");
        lookup(1, 1, 32'h20AB_CDEF, 1, 1, 0, 32'h2012_3456, "R6 load allowed");
        // R11: sides independent
        lookup(0, 1, 32'h0040_0010, 1, 1, 1, 32'h0000_0010, "R11 mixed modes");
        lookup(1, 1, 32'h0040_0010, 0, 1, 1, 32'h0000_0010, "R11 mixed modes rev");

        // R4: overlapping entries, lowest index wins
        tbl_write(9, 0, 32'h3000_00C0);
        tbl_write(9, 1, 32'h0AAA_0300);
        tbl_write(5, 0, 32'h3000_0340);
        tbl_write(5, 1, 32'h0BC0_0304);
        lookup(1, 1, 32'h3000_0123, 1, 1, 0, 32'h3000_0FFF, "R4 priority");

        // R10: same-cycle write sees old, next cycle sees new
        tbl_write(3, 1, 32'h0550_0300);
        @(negedge clk);
        tbl_we = 1; tbl_idx = 6'd3; tbl_word = 0; tbl_wdata = 32'h5000_0040;
        i_xlate = 1; i_req = 1; i_ea = 32'h5000_0010;
        d_xlate = 1; d_req = 1; d_store = 0; d_ea = 32'h5000_0010;
        #1;
        check_both("R10 write cycle old entry");
        @(posedge clk);
        #0.5;
        m_tag[3] = 32'h5000_0040;
        @(negedge clk);
        tbl_we = 0;
        #1;
        check_both("R10 next cycle new entry");

        // R5: explicit miss
        lookup(1, 1, 32'hE000_0000, 1, 1, 1, 32'hE100_0000, "R5 miss");

        // random table fill and lookups
        for (int k = 10; k < 64; k++) begin
            base = 32'h4000_0000 | (32'($urandom_range(0, 7)) << 24);
            a1 = base | ($urandom & 32'h00FF_FC00) | (32'($urandom_range(0, 7)) << 7)
                 | (($urandom_range(0, 4) != 0) ? 32'h40 : 32'h0) | ($urandom & 32'h3F);
            tbl_write(k, 0, a1);
            tbl_write(k, 1, $urandom);
        end
        for (int n = 0; n < 3000; n++) begin
            if (n % 400 == 0) cfg_write(2'($urandom_range(0, 3)), $urandom);
            a1 = 32'h4000_0000 | (32'($urandom_range(0, 7)) << 24) | ($urandom & 32'h00FF_FFFF);
            a2 = ($urandom_range(0, 3) == 0) ? $urandom
                 : (32'h4000_0000 | (32'($urandom_range(0, 7)) << 24) | ($urandom & 32'h00FF_FFFF));
            lookup($urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0, a1,
                   $urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0, 1'($urandom), a2,
                   "R2 R3 R4 R6 R7 R8 R9 R12 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule